// File: doc/BRIEF.md
# HTTP Request Destination Classifier

This block watches the payload of each HTTP request as it streams past, one byte per clock, and picks the server class that should receive it. Header parsing has already taken place upstream; the block sees only payload bytes, marked with a valid strobe and a marker on the final byte of the packet. It looks for two substrings anywhere in the request: an image extension (".jpg" by default) and an application path segment ("cgi-bin/" by default).

When the final byte has been taken in, the block reports a destination code for one cycle. A request with the application segment goes to the application server. One with only the image extension goes to the image server. Any other request goes to the HTML server. All matching state is then cleared, so each packet is judged on its own bytes. The input is never stalled. Typical traffic is a request line such as "GET /cgi-bin/form HTTP/1.1" followed by a Host line.

Top module: `url_class_switch`

## Requirements
- R1: A packet whose bytes contain the image substring gives dest_code 2'd1 (image server), provided the application substring is absent.
- R2: A packet whose bytes contain the application substring gives dest_code 2'd2 (application server).
- R3: A packet that contains neither substring gives dest_code 2'd0 (HTML server).
- R4: When both substrings occur in one packet, in either order, dest_code is 2'd2.
- R5: A substring is found at any byte offset, including straight after a partial or overlapping prefix (for example "..jpg" or "cgi-cgi-bin/"), and including when its last character is the packet's last byte.
- R6: dest_valid is high for exactly the one cycle after the clock edge that accepts a byte with in_valid=1 and in_last=1, and dest_code carries the decision in that cycle.
- R7: dest_code holds its value until the next decision.
- R8: All match state clears at packet end. A substring split across two packets is not found, and a hit in one packet has no effect on the next.
- R9: Cycles with in_valid=0 inside a packet neither advance nor break a partial match.
- R10: While rst_n is low at a clock edge, the block sets dest_valid=0 and dest_code=2'd0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Payload byte present this cycle |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final byte of the packet |
| dest_valid | output | 1 | One-cycle decision strobe |
| dest_code | output | 2 | 0 = HTML, 1 = image, 2 = application |

## Verification
The bench builds the block with its default patterns: a four-byte image pattern and an eight-byte application pattern. At these lengths the history windows are short enough that a pattern ending on the packet's last byte, overlapping prefixes and patterns split across a packet boundary can all be shown with short directed strings. The two patterns also differ in length, so both the small and the large window depth are exercised. A one-byte packet, two packets sent back to back and idle gaps placed inside a pattern cover the edges of the decision timing.

// File: rtl/url_cls_pkg.sv
// Shared encodings for the request classifier.
package url_cls_pkg;
    typedef enum logic [1:0] {
        DEST_HTML  = 2'd0,
        DEST_IMAGE = 2'd1,
        DEST_APP   = 2'd2
    } dest_e;
endpackage

// File: rtl/url_pat_matcher.sv
// Streaming substring detector for one fixed pattern.
// It keeps the previous LEN-1 accepted bytes and compares them with the
// current byte against the pattern, so overlaps need no restart logic.
// Assumes LEN >= 2. The first pattern character sits in the MSB byte of PAT.
// found is combinational: sticky hit of this packet OR a hit on this byte.
module url_pat_matcher #(
    parameter int              LEN = 4,
    parameter logic [8*LEN-1:0] PAT = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       byte_last,
    output logic       found
);
    localparam int HL = LEN - 1;
    localparam int CW = $clog2(LEN) + 1;

    logic [7:0]    hist_q [HL];
    logic [CW-1:0] fill_q;
    logic          seen_q;
    logic [LEN-1:0] eq;
    logic          hit;

    // Per-position comparison of the current byte and the history against the pattern.
    assign eq[LEN-1] = (byte_data == PAT[7:0]);
    generate
        for (genvar k = 0; k < HL; k++) begin : g_cmp
            assign eq[k] = (hist_q[k] == PAT[8*(k+1)+7 -: 8]);
        end
    endgenerate

    // A hit needs a full window of bytes from this packet.
    assign hit   = byte_valid && (&eq) && (fill_q >= CW'(HL));
    assign found = seen_q || hit;

    // History shift, fill count and sticky hit; everything clears on the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HL; i++) hist_q[i] <= '0;
            fill_q <= '0;
            seen_q <= 1'b0;
        end else if (byte_valid) begin
            if (byte_last) begin
                for (int i = 0; i < HL; i++) hist_q[i] <= '0;
                fill_q <= '0;
                seen_q <= 1'b0;
            end else begin
                hist_q[0] <= byte_data;
                for (int i = 1; i < HL; i++) hist_q[i] <= hist_q[i-1];
                if (fill_q < CW'(HL)) fill_q <= fill_q + 1'b1;
                seen_q <= seen_q || hit;
            end
        end
    end

    // R8: the fill count never exceeds the window depth.
    a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CW'(HL));
    // R8: state is empty after a last byte.
    a_r8_clear_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_last) |=> (!seen_q && fill_q == '0));
    // R9: an idle cycle leaves the match state untouched.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> ($stable(fill_q) && $stable(seen_q)));
endmodule

// File: rtl/url_dest_select.sv
// Turns the two pattern flags into a registered destination code and strobe.
// The application flag outranks the image flag; neither means HTML.
// Assumes the flags are valid in the cycle of the last byte.
module url_dest_select
    import url_cls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pkt_end,
    input  logic       img_found,
    input  logic       app_found,
    output logic       dec_valid,
    output dest_e      dec_code
);
    dest_e pick;

    // Priority choice between the server classes.
    always_comb begin
        if (app_found)      pick = DEST_APP;
        else if (img_found) pick = DEST_IMAGE;
        else                pick = DEST_HTML;
    end

    // Register the decision at packet end and hold it until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_code  <= DEST_HTML;
        end else begin
            dec_valid <= pkt_end;
            if (pkt_end) dec_code <= pick;
        end
    end

    // R6: the strobe only follows an accepted last byte.
    a_r6_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(pkt_end));
    // R7: the code holds when no decision is made.
    a_r7_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> $stable(dec_code));
    // R4: an application hit at packet end always wins.
    a_r4_app_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && app_found) |=> (dec_code == DEST_APP));
    // R3: the code is always one of the three legal values.
    a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        dec_code != 2'd3);
endmodule

// File: rtl/url_class_switch.sv
// Top of the request classifier: two pattern matchers feed the destination selector.
// Takes one payload byte per cycle and never back-pressures.
module url_class_switch
    import url_cls_pkg::*;
#(
    parameter int                   IMG_LEN = 4,
    parameter logic [8*IMG_LEN-1:0] IMG_PAT = ".jpg",
    parameter int                   APP_LEN = 8,
    parameter logic [8*APP_LEN-1:0] APP_PAT = "cgi-bin/"
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       dest_valid,
    output logic [1:0] dest_code
);
    logic  img_hit;
    logic  app_hit;
    logic  pkt_end;
    dest_e code_e;

    assign pkt_end = in_valid && in_last;

    url_pat_matcher #(.LEN(IMG_LEN), .PAT(IMG_PAT)) u_img (
        .clk(clk), .rst_n(rst_n), .byte_valid(in_valid), .byte_data(in_data),
        .byte_last(in_last), .found(img_hit)
    );

    url_pat_matcher #(.LEN(APP_LEN), .PAT(APP_PAT)) u_app (
        .clk(clk), .rst_n(rst_n), .byte_valid(in_valid), .byte_data(in_data),
        .byte_last(in_last), .found(app_hit)
    );

    url_dest_select u_sel (
        .clk(clk), .rst_n(rst_n), .pkt_end(pkt_end),
        .img_found(img_hit), .app_found(app_hit),
        .dec_valid(dest_valid), .dec_code(code_e)
    );

    assign dest_code = code_e;
endmodule

// File: tb/tb_url_class_switch.sv
module tb_url_class_switch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       dest_valid;
    logic [1:0] dest_code;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    url_class_switch dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .dest_valid(dest_valid), .dest_code(dest_code)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sends a packet; gap idle cycles after byte index gap_at (-1 = none).
    task automatic send(input string s, input int gap_at, input int gap);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = s[i];
            in_last  = (i == s.len() - 1);
            if (i == gap_at && i != s.len() - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // Sends one packet and checks the strobe and code one cycle later.
    task automatic pkt_check(input string req, input string s, input int exp, input int gap_at, input int gap);
        send(s, gap_at, gap);
        check({req, " strobe"}, dest_valid, 1);
        check({req, " code"}, dest_code, exp);
        @(negedge clk);
        check("R6 pulse width", dest_valid, 0);
    endtask

    task automatic t_reset();
        check("R10 reset valid", dest_valid, 0);
        check("R10 reset code", dest_code, 0);
    endtask

    task automatic t_basic();
        pkt_check("R1 image", "GET /pics/cat.jpg HTTP/1.1", 1, -1, 0);
        pkt_check("R2 app", "GET /cgi-bin/form HTTP/1.1", 2, -1, 0);
        pkt_check("R3 html", "GET /index.html HTTP/1.1", 0, -1, 0);
        pkt_check("R3 near miss", "GET /cgi-bin.jp HTTP/1.1", 0, -1, 0);
    endtask

    task automatic t_both();
        pkt_check("R4 img first", "GET /a.jpg/cgi-bin/x", 2, -1, 0);
        pkt_check("R4 app first", "GET /cgi-bin/a.jpg", 2, -1, 0);
    endtask

    task automatic t_overlap();
        pkt_check("R5 double dot", "x..jpg", 1, -1, 0);
        pkt_check("R5 repeated prefix", "/cgi-cgi-bin/q", 2, -1, 0);
        pkt_check("R5 at packet end", "cgi-bin/", 2, -1, 0);
        pkt_check("R5 image at end", "a.jpg", 1, -1, 0);
    endtask

    task automatic t_hold_and_clear();
        pkt_check("R8 after app", "plain", 0, -1, 0);
        pkt_check("R8 split part1", "abc.j", 0, -1, 0);
        pkt_check("R8 split part2", "pg zz", 0, -1, 0);
        pkt_check("R1 before hold", "q.jpg", 1, -1, 0);
        for (int i = 0; i < 4; i++) @(negedge clk);
        check("R7 held code", dest_code, 1);
        check("R7 no strobe", dest_valid, 0);
    endtask

    task automatic t_gaps_and_edges();
        pkt_check("R9 gap in pattern", "GET /cgi-bin/x", 2, 7, 3);
        pkt_check("R9 gap in image", "z.jpg", 1, 2, 2);
        pkt_check("R6 one byte packet", "j", 0, -1, 0);
        // Back-to-back packets: strobe for the first arrives while the second streams.
        @(negedge clk);
        in_valid = 1'b1; in_data = "."; in_last = 1'b0;
        @(negedge clk); in_data = "j";
        @(negedge clk); in_data = "p";
        @(negedge clk); in_data = "g"; in_last = 1'b1;
        @(negedge clk); in_data = "h"; in_last = 1'b1;
        check("R6 back2back first strobe", dest_valid, 1);
        check("R6 back2back first code", dest_code, 1);
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
        check("R6 back2back second strobe", dest_valid, 1);
        check("R8 back2back second code", dest_code, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_both();
        t_overlap();
        t_hold_and_clear();
        t_gaps_and_edges();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule